// File: doc/BRIEF.md
# Non-volatile wiper slot store

The block is a bank of sixteen 9-bit words, four slots for each of four potentiometer channels, that behaves like erasable non-volatile storage. Each word holds an 8-bit wiper code in bits 7:0 and a buffer-mode flag in bit 8. A command executor drives one request per cycle. Erase sets a word to all ones. Program combines its data into the word with a bitwise AND, so a slot has to be erased before it can take an arbitrary value. A save request programs the slot with the tap word of the channel, which the executor supplies. Read and load requests return a stored word.

Selected requests start an internal access cycle. The cycle lasts a parameterised number of clock cycles, and during it the active-high ready output is held low. The store is written, or read, at the end of the cycle. After the cycle a short guard window follows. A request that arrives during the cycle or the guard window is refused and flagged. A write-protect input, active low, blocks every change to the store but still lets reads and loads through. A falling edge on the chip-select input releases the ready output early. The internal cycle still runs to its end.

Top module: `nv_slot_store`

## Requirements
- R1: After reset `rdy_o` is 1, `err_o`, `rd_valid_o` and `load_valid_o` are 0, and every word reads 9'h1FF.
- R2: An erase request (op code 6) that is accepted with `wp_n_i` high sets the addressed word to 9'h1FF in the acceptance cycle.
- R3: A program request (op code 3) sets the addressed word to the old word AND `req_data_i`, so on an erased word the result equals `req_data_i`.
- R4: A program request on a word that was not erased first leaves the bitwise AND of the old and new values, not the new value.
- R5: An accepted request with op code 1 (read tap), 2 (read slot), 3 (program), 4 (load) or 5 (save) holds `rdy_o` low for exactly STORE_CYCLES cycles, starting in the cycle after acceptance.
- R6: An accepted request with op code 0 (no-op), 6 (erase) or 7 (reserved) leaves `rdy_o` high.
- R7: A read-slot request gives a one-cycle `rd_valid_o` pulse, carrying the word in `rd_data_o`, in the first cycle that `rdy_o` is high again.
- R8: A load request gives a one-cycle `load_valid_o` pulse, carrying the word in `load_data_o` and the channel in `load_chan_o`, at the same point as in R7.
- R9: A save request programs the addressed word with `tap_word_i`, sampled at acceptance, using the AND rule of R3.
- R10: When `wp_n_i` is low at acceptance, erase, program and save requests leave the store unchanged, while read and load requests work as usual.
- R11: A request that arrives while the access cycle runs, or within GUARD_CYCLES cycles after it ends, has no effect, and `err_o` pulses in the next cycle.
- R12: A falling edge of `cs_n_i` during an access cycle drives `rdy_o` high from the next cycle. The cycle still completes on schedule, and new requests are still refused until the guard window ends.
- R13: The word address is `{req_chan_i, req_slot_i}`, and a request changes only the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low; a falling edge releases ready |
| wp_n_i | input | 1 | Write protect, active low |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Request op code |
| req_chan_i | input | 2 | Channel address |
| req_slot_i | input | 2 | Slot address within the channel |
| req_data_i | input | 9 | Program data |
| tap_word_i | input | 9 | Current tap word, used by save |
| rdy_o | output | 1 | Ready, low while an access cycle is held |
| err_o | output | 1 | Refused-request strobe |
| rd_valid_o | output | 1 | Read data strobe |
| rd_data_o | output | 9 | Read data |
| load_valid_o | output | 1 | Load-to-tap strobe |
| load_chan_o | output | 2 | Channel for the load |
| load_data_o | output | 9 | Word for the load |

## Verification
The hardest state to reach is a chip-select fall during a running access cycle. In that state `rdy_o` is already high, yet the block is still busy and still refuses requests. The stimulus starts a read, lowers `cs_n_i` two cycles later, and then places a request in the released window. It then checks for the error strobe and for read data that arrives at the cycle the unbroken schedule predicts. Refusals in the guard window are reached the same way: a request is driven in the very first cycle after `rdy_o` comes back.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_RD_TAP  = 3'd1,
    OP_RD_SLOT = 3'd2,
    OP_PROG    = 3'd3,
    OP_LOAD    = 3'd4,
    OP_SAVE    = 3'd5,
    OP_ERASE   = 3'd6,
    OP_RSVD    = 3'd7
  } nvs_op_e;

  // ops that hold ready low for a store cycle
  function automatic logic op_flow(nvs_op_e op);
    return op inside {OP_RD_TAP, OP_RD_SLOT, OP_PROG, OP_LOAD, OP_SAVE};
  endfunction

  // ops that write a word at cycle end
  function automatic logic op_store(nvs_op_e op);
    return (op == OP_PROG) || (op == OP_SAVE);
  endfunction
endpackage

// File: rtl/nvs_array.sv
module nvs_array #(
  parameter int N_WORDS = 16,
  parameter int WORD_W  = 9,
  localparam int AW     = $clog2(N_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic              prog_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] mask_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] words [N_WORDS];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              hit;
    assign hit = (addr_i == AW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            word_q <= '1;
      else if (erase_i && hit) word_q <= '1;
      else if (prog_i && hit)  word_q <= word_q & mask_i;  // cells only clear
    end
    assign words[g] = word_q;
  end

  assign rdata_o = words[raddr_i];
endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int STORE_CYCLES = 8,
  parameter int GUARD_CYCLES = 2,
  localparam int CNT_W = $clog2(STORE_CYCLES + 1),
  localparam int GRD_W = $clog2(GUARD_CYCLES + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic guard_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [GRD_W-1:0] grd_q;
  logic             busy_q;

  assign busy_o  = busy_q;
  assign done_o  = busy_q && (cnt_q == '0);
  assign guard_o = (grd_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      grd_q  <= '0;
    end else begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(STORE_CYCLES - 1);
      end else if (done_o) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (done_o)       grd_q <= GRD_W'(GUARD_CYCLES);
      else if (guard_o) grd_q <= grd_q - 1'b1;
    end
  end
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int CH_W   = 2,
  parameter int SL_W   = 2,
  parameter int WORD_W = 9,
  localparam int AW    = CH_W + SL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              wp_n_i,
  input  logic              req_valid_i,
  input  nvs_op_e           req_op_i,
  input  logic [CH_W-1:0]   req_chan_i,
  input  logic [SL_W-1:0]   req_slot_i,
  input  logic [WORD_W-1:0] req_data_i,
  input  logic [WORD_W-1:0] tap_word_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              guard_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              accept_o,
  output logic              cs_fall_o,
  output logic              start_o,
  output logic              erase_o,
  output logic              prog_o,
  output logic [AW-1:0]     addr_o,
  output logic [AW-1:0]     raddr_o,
  output logic [WORD_W-1:0] mask_o,
  output logic              rdy_o,
  output logic              err_o,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              load_valid_o,
  output logic [CH_W-1:0]   load_chan_o,
  output logic [WORD_W-1:0] load_data_o
);
  nvs_op_e           op_q;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] data_q, tap_q;
  logic              wp_ok_q, released_q, cs_q, err_q;
  logic              rd_valid_q, load_valid_q;
  logic [WORD_W-1:0] rd_data_q, load_data_q;
  logic [CH_W-1:0]   load_chan_q;

  assign accept_o  = req_valid_i && !busy_i && !guard_i;
  assign cs_fall_o = cs_q && !cs_n_i;
  assign start_o   = accept_o && op_flow(req_op_i);
  assign erase_o   = accept_o && (req_op_i == OP_ERASE) && wp_n_i;
  assign prog_o    = done_i && op_store(op_q) && wp_ok_q;
  assign addr_o    = busy_i ? addr_q : {req_chan_i, req_slot_i};
  assign raddr_o   = addr_q;
  assign mask_o    = (op_q == OP_SAVE) ? tap_q : data_q;

  assign rdy_o        = !busy_i || released_q;
  assign err_o        = err_q;
  assign rd_valid_o   = rd_valid_q;
  assign rd_data_o    = rd_data_q;
  assign load_valid_o = load_valid_q;
  assign load_chan_o  = load_chan_q;
  assign load_data_o  = load_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_NOP;
      addr_q  <= '0;
      data_q  <= '0;
      tap_q   <= '0;
      wp_ok_q <= 1'b1;
    end else if (accept_o) begin
      op_q    <= req_op_i;
      addr_q  <= {req_chan_i, req_slot_i};
      data_q  <= req_data_i;
      tap_q   <= tap_word_i;
      wp_ok_q <= wp_n_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q       <= 1'b1;
      released_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      cs_q  <= cs_n_i;
      err_q <= req_valid_i && !accept_o;
      if (accept_o || done_i)        released_q <= 1'b0;
      else if (cs_fall_o && busy_i)  released_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q   <= 1'b0;
      rd_data_q    <= '0;
      load_valid_q <= 1'b0;
      load_data_q  <= '0;
      load_chan_q  <= '0;
    end else begin
      rd_valid_q   <= done_i && (op_q == OP_RD_SLOT);
      load_valid_q <= done_i && (op_q == OP_LOAD);
      if (done_i && op_q == OP_RD_SLOT) rd_data_q <= rdata_i;
      if (done_i && op_q == OP_LOAD) begin
        load_data_q <= rdata_i;
        load_chan_q <= addr_q[AW-1:SL_W];
      end
    end
  end
endmodule

// File: rtl/nv_slot_store.sv
module nv_slot_store
  import nvs_pkg::*;
#(
  parameter int N_CHAN       = 4,
  parameter int N_SLOT       = 4,
  parameter int WORD_W       = 9,
  parameter int STORE_CYCLES = 8,
  parameter int GUARD_CYCLES = 2,
  localparam int CH_W    = $clog2(N_CHAN),
  localparam int SL_W    = $clog2(N_SLOT),
  localparam int N_WORDS = N_CHAN * N_SLOT,
  localparam int AW      = CH_W + SL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              wp_n_i,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [CH_W-1:0]   req_chan_i,
  input  logic [SL_W-1:0]   req_slot_i,
  input  logic [WORD_W-1:0] req_data_i,
  input  logic [WORD_W-1:0] tap_word_i,
  output logic              rdy_o,
  output logic              err_o,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              load_valid_o,
  output logic [CH_W-1:0]   load_chan_o,
  output logic [WORD_W-1:0] load_data_o
);
  logic              accept_w, cs_fall_w, start_w, erase_w, prog_w;
  logic              busy_w, done_w, guard_w;
  logic [AW-1:0]     addr_w, raddr_w;
  logic [WORD_W-1:0] mask_w, rdata_w;

  nvs_timer #(
    .STORE_CYCLES(STORE_CYCLES),
    .GUARD_CYCLES(GUARD_CYCLES)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_w),
    .busy_o (busy_w),
    .done_o (done_w),
    .guard_o(guard_w)
  );

  nvs_ctrl #(
    .CH_W  (CH_W),
    .SL_W  (SL_W),
    .WORD_W(WORD_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_n_i      (cs_n_i),
    .wp_n_i      (wp_n_i),
    .req_valid_i (req_valid_i),
    .req_op_i    (nvs_op_e'(req_op_i)),
    .req_chan_i  (req_chan_i),
    .req_slot_i  (req_slot_i),
    .req_data_i  (req_data_i),
    .tap_word_i  (tap_word_i),
    .busy_i      (busy_w),
    .done_i      (done_w),
    .guard_i     (guard_w),
    .rdata_i     (rdata_w),
    .accept_o    (accept_w),
    .cs_fall_o   (cs_fall_w),
    .start_o     (start_w),
    .erase_o     (erase_w),
    .prog_o      (prog_w),
    .addr_o      (addr_w),
    .raddr_o     (raddr_w),
    .mask_o      (mask_w),
    .rdy_o       (rdy_o),
    .err_o       (err_o),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .load_valid_o(load_valid_o),
    .load_chan_o (load_chan_o),
    .load_data_o (load_data_o)
  );

  nvs_array #(
    .N_WORDS(N_WORDS),
    .WORD_W (WORD_W)
  ) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .erase_i(erase_w),
    .prog_i (prog_w),
    .addr_i (addr_w),
    .mask_i (mask_w),
    .raddr_i(raddr_w),
    .rdata_o(rdata_w)
  );
endmodule

// File: rtl/nvs_checker.sv
module nvs_checker
  import nvs_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [2:0] req_op_i,
  input logic       accept_i,
  input logic       busy_i,
  input logic       cs_fall_i,
  input logic       rdy_o,
  input logic       err_o,
  input logic       rd_valid_o,
  input logic       load_valid_o
);
  p_flow_drops_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && op_flow(nvs_op_e'(req_op_i)) |=> !rdy_o);

  p_plain_keeps_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && !op_flow(nvs_op_e'(req_op_i)) && rdy_o |=> rdy_o);

  p_refused_flags_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !accept_i |=> err_o);

  p_err_needs_request_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_valid_i));

  p_cs_release_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i && busy_i |=> rdy_o);

  p_read_when_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rdy_o);

  p_one_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_valid_o, load_valid_o}));
endmodule

bind nv_slot_store nvs_checker u_nvs_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .accept_i    (accept_w),
  .busy_i      (busy_w),
  .cs_fall_i   (cs_fall_w),
  .rdy_o       (rdy_o),
  .err_o       (err_o),
  .rd_valid_o  (rd_valid_o),
  .load_valid_o(load_valid_o)
);

// File: tb/tb_nv_slot_store.sv
module tb_nv_slot_store;
  localparam int SC = 8;
  localparam int GC = 2;
  localparam logic [2:0] NOP = 3'd0, RTAP = 3'd1, RSLT = 3'd2, PROG = 3'd3,
                         LOAD = 3'd4, SAVE = 3'd5, ERAS = 3'd6, RSVD = 3'd7;

  // {op, ch, sl, data, tap, wp_n, expected word}
  localparam logic [34:0] VEC [10] = '{
    {PROG, 2'd0, 2'd0, 9'h0A5, 9'h000, 1'b1, 9'h0A5},
    {PROG, 2'd0, 2'd0, 9'h13C, 9'h000, 1'b1, 9'h024},
    {ERAS, 2'd0, 2'd0, 9'h000, 9'h000, 1'b1, 9'h1FF},
    {PROG, 2'd0, 2'd0, 9'h13C, 9'h000, 1'b1, 9'h13C},
    {SAVE, 2'd1, 2'd2, 9'h000, 9'h155, 1'b1, 9'h155},
    {ERAS, 2'd1, 2'd2, 9'h000, 9'h000, 1'b0, 9'h155},
    {PROG, 2'd1, 2'd2, 9'h000, 9'h000, 1'b0, 9'h155},
    {PROG, 2'd3, 2'd3, 9'h001, 9'h000, 1'b1, 9'h001},
    {RSLT, 2'd3, 2'd3, 9'h000, 9'h000, 1'b1, 9'h001},
    {LOAD, 2'd1, 2'd2, 9'h000, 9'h000, 1'b0, 9'h155}
  };
  localparam string TAG [10] = '{"R3", "R4", "R2", "R3", "R9",
                                 "R10", "R10", "R13", "R7", "R8"};

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs_n = 1'b1, wp_n = 1'b1, req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [1:0] req_ch = '0, req_sl = '0;
  logic [8:0] req_data = '0, tap = '0;
  logic       rdy, err, rd_valid, ld_valid;
  logic [8:0] rd_data, ld_data;
  logic [1:0] ld_chan;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  int         cap_low;
  logic       cap_rdv, cap_ldv;
  logic [8:0] cap_rdd, cap_ldd;
  logic [1:0] cap_ldch;

  always #5 clk = ~clk;

  nv_slot_store dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .wp_n_i(wp_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_chan_i(req_ch),
    .req_slot_i(req_sl), .req_data_i(req_data), .tap_word_i(tap),
    .rdy_o(rdy), .err_o(err), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .load_valid_o(ld_valid), .load_chan_o(ld_chan), .load_data_o(ld_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] ch,
                       input logic [1:0] sl, input logic [8:0] d,
                       input logic [8:0] t, input logic w);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_ch = ch; req_sl = sl;
    req_data = d; tap = t; wp_n = w;
    @(negedge clk);
    req_valid = 1'b0; wp_n = 1'b1;
    cap_low = 0;
    while (!rdy && cap_low < 1000) begin
      cap_low++;
      @(negedge clk);
    end
    cap_rdv = rd_valid; cap_rdd = rd_data;
    cap_ldv = ld_valid; cap_ldd = ld_data; cap_ldch = ld_chan;
  endtask

  task automatic wait_guard();
    repeat (GC) @(negedge clk);
  endtask

  task automatic read_slot(input logic [1:0] ch, input logic [1:0] sl,
                           output logic [8:0] val);
    issue(RSLT, ch, sl, 9'h0, 9'h0, 1'b1);
    val = cap_rdd;
    wait_guard();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [8:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rdy == 1'b1 && !err && !rd_valid && !ld_valid, "R1",
        {rdy, err, rd_valid, ld_valid}, 4'b1000);
    read_slot(2'd2, 2'd1, rv);
    chk(rv == 9'h1FF, "R1", rv, 9'h1FF);

    for (int i = 0; i < 10; i++) begin
      logic [34:0] v;
      logic [2:0]  op;
      v  = VEC[i];
      op = v[34:32];
      issue(op, v[31:30], v[29:28], v[27:19], v[18:10], v[9]);
      if (op inside {RTAP, RSLT, PROG, LOAD, SAVE})
        chk(cap_low == SC, "R5", cap_low, SC);
      else
        chk(cap_low == 0, "R6", cap_low, 0);
      if (op == RSLT)
        chk(cap_rdv && cap_rdd == v[8:0], "R7", {cap_rdv, cap_rdd}, {1'b1, v[8:0]});
      if (op == LOAD)
        chk(cap_ldv && cap_ldd == v[8:0] && cap_ldch == v[31:30], "R8",
            {cap_ldv, cap_ldch, cap_ldd}, {1'b1, v[31:30], v[8:0]});
      wait_guard();
      read_slot(v[31:30], v[29:28], rv);
      chk(rv == v[8:0], TAG[i], rv, v[8:0]);
    end

    // R13 neighbour untouched
    read_slot(2'd0, 2'd1, rv);
    chk(rv == 9'h1FF, "R13", rv, 9'h1FF);

    // R5 read tap holds ready, R6 reserved op does not
    issue(RTAP, 2'd2, 2'd0, 9'h0, 9'h0, 1'b1);
    chk(cap_low == SC && !cap_rdv && !cap_ldv, "R5", cap_low, SC);
    wait_guard();
    issue(RSVD, 2'd2, 2'd0, 9'h0, 9'h0, 1'b1);
    chk(cap_low == 0 && !err, "R6", cap_low, 0);
    wait_guard();

    // R11 refusal while busy
    @(negedge clk);
    req_valid = 1'b1; req_op = PROG; req_ch = 2'd2; req_sl = 2'd0; req_data = 9'h0F0;
    @(negedge clk);
    req_sl = 2'd1; req_data = 9'h000;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err == 1'b1, "R11", err, 1);
    while (!rdy) @(negedge clk);
    // R11 refusal in guard window
    req_valid = 1'b1; req_op = PROG; req_sl = 2'd2; req_data = 9'h000;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err == 1'b1, "R11", err, 1);
    wait_guard();
    read_slot(2'd2, 2'd0, rv);
    chk(rv == 9'h0F0, "R3", rv, 9'h0F0);
    read_slot(2'd2, 2'd1, rv);
    chk(rv == 9'h1FF, "R11", rv, 9'h1FF);
    read_slot(2'd2, 2'd2, rv);
    chk(rv == 9'h1FF, "R11", rv, 9'h1FF);

    // R12 chip-select release during a read
    @(negedge clk);
    req_valid = 1'b1; req_op = RSLT; req_ch = 2'd2; req_sl = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rdy == 1'b0, "R12", rdy, 0);
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    chk(rdy == 1'b1, "R12", rdy, 1);
    req_valid = 1'b1; req_op = NOP;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err == 1'b1, "R12", err, 1);
    repeat (SC - 3) @(negedge clk);
    chk(rd_valid && rd_data == 9'h0F0, "R12", {rd_valid, rd_data}, {1'b1, 9'h0F0});
    cs_n = 1'b1;
    repeat (GC + 1) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule